// File: doc/BRIEF.md
# Strap-Indexed Synthesizer Setting Selector

This block keeps eight rows of settings for the first frequency synthesizer. Each row holds an 11-bit feedback multiplier P, an 8-bit reference divider Q and one bank bit. It also keeps two banks of 7-bit post-divider values, and each bank feeds two outputs, A and B. A 3-bit index picks the active row. The two low index bits come from the serial data pin and the serial clock pin, and they are captured only once, in the first clock cycle after reset. The high index bit follows a live general-purpose pin. That pin passes through a two-flop synchronizer and must hold its new level long enough before the selector accepts it.

The active row drives P, Q and the bank bit straight to the synthesizer logic downstream. The bank bit chooses which pair of divider values the two post-dividers load. Each post-divider takes a new ratio only at its terminal count. As a result, every interval between output ticks is a whole period at either the old ratio or the new one.

A control state machine has three states. ST_STRAP is entered on reset and captures the straps. It always moves to ST_RUN. ST_RUN is the steady state, and it moves to ST_QUAL when the synchronized pin disagrees with index bit 2. ST_QUAL goes back to ST_RUN in two cases: when the pin agrees again, which abandons the change, or when the disagreement has lasted long enough, which commits the change. The table is loaded through a single-cycle write port.

Top module: `fsel_table`

## Requirements
- R1: While `rst_n` is low, `cfg_valid`, `sel_idx`, `tick_a` and `tick_b` are all 0. No tick occurs while `cfg_valid` is 0.
- R2: At the first rising clock edge after reset, `sel_idx[0]` takes `strap_sda` and `sel_idx[1]` takes `strap_scl`, and `cfg_valid` rises and then stays high. Later changes on the strap pins have no effect on `sel_idx`.
- R3: `sel_idx[2]` follows `sel_live` through a two-flop synchronizer. A new level that is held for at least QUAL_CYC+1 consecutive clock cycles is adopted. A pulse that is shorter is ignored.
- R4: `pll_p`, `pll_q` and `bank_sel` show the row addressed by `sel_idx`. The row word packs P in bits [10:0], Q in bits [18:11] and the bank bit in bit 19.
- R5: A write with `wr_en` high and `wr_addr[3]`=0 loads row `wr_addr[2:0]`. A write with `wr_addr[3:1]`=100 loads bank `wr_addr[0]`, with the output A value in `wr_data[6:0]` and the output B value in `wr_data[13:7]`. A write to an active row shows on the outputs in the next cycle.
- R6: Each post-divider with active value D raises its tick for one cycle every D cycles. A D of 0 acts as 1, so the tick stays high every cycle.
- R7: A post-divider takes a new value only in a cycle in which its tick is high. Every interval between ticks therefore equals either the old value or the new value, whether the change comes from an index switch or from a bank write.
- R8: Both post-dividers take their values from the same bank, the one given by `bank_sel`.
- R9: `pll_p`, `pll_q` and `bank_sel` stay unchanged unless `sel_idx` changes or a write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sda | input | 1 | Serial data pin, sampled as index bit 0 at start-up |
| strap_scl | input | 1 | Serial clock pin, sampled as index bit 1 at start-up |
| sel_live | input | 1 | Live select pin, index bit 2 (asynchronous) |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Row (MSB 0) or divider bank (MSB 1) address |
| wr_data | input | 20 | Row word or pair of divider values |
| sel_idx | output | 3 | Active row index |
| cfg_valid | output | 1 | Straps captured; dividers running |
| pll_p | output | 11 | Active feedback multiplier |
| pll_q | output | 8 | Active reference divider |
| bank_sel | output | 1 | Active divider bank |
| div_a_act | output | 7 | Ratio currently used by post-divider A |
| div_b_act | output | 7 | Ratio currently used by post-divider B |
| tick_a | output | 1 | Terminal-count pulse of post-divider A |
| tick_b | output | 1 | Terminal-count pulse of post-divider B |

## Verification
The bench builds the block with QUAL_CYC=2 and eight rows. Under these settings, select pulses of one and two cycles fall just short of the qualification window, and a held level falls just past it, so the boundary of R3 is exercised on both sides. The divider ratios 3, 4, 5, 6, 9 and 0 are short enough that a bank switch can be watched interval by interval, both in a single window around an index change and around a bank rewrite.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    parameter int P_W  = 11;
    parameter int Q_W  = 8;
    parameter int D_W  = 7;
    parameter int ROWS = 8;

    localparam int IDX_W  = $clog2(ROWS);
    localparam int ADDR_W = IDX_W + 1;
    localparam int ROW_W  = P_W + Q_W + 1;
    localparam int DATA_W = (ROW_W > 2 * D_W) ? ROW_W : 2 * D_W;

    typedef struct packed {
        logic           bank;
        logic [Q_W-1:0] q;
        logic [P_W-1:0] p;
    } row_t;

    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_RUN   = 2'd1,
        ST_QUAL  = 2'd2
    } sel_state_t;
endpackage

// File: rtl/fsel_store.sv
module fsel_store
    import fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output row_t              rd_row,
    output logic [D_W-1:0]    div_a_tgt,
    output logic [D_W-1:0]    div_b_tgt
);
    row_t           rows   [ROWS];
    logic [D_W-1:0] bank_a [2];
    logic [D_W-1:0] bank_b [2];

    logic is_row_wr;
    logic is_bank_wr;

    assign is_row_wr  = wr_en && !wr_addr[ADDR_W-1];
    assign is_bank_wr = wr_en && wr_addr[ADDR_W-1] && (wr_addr[ADDR_W-2:1] == '0);

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        row_t r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (is_row_wr && (wr_addr[IDX_W-1:0] == IDX_W'(g))) begin
                r_q <= wr_data[ROW_W-1:0];
            end
        end
        assign rows[g] = r_q;
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [D_W-1:0] a_q;
        logic [D_W-1:0] b_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
            end else if (is_bank_wr && (wr_addr[0] == 1'(b))) begin
                a_q <= wr_data[D_W-1:0];
                b_q <= wr_data[2*D_W-1:D_W];
            end
        end
        assign bank_a[b] = a_q;
        assign bank_b[b] = b_q;
    end

    assign rd_row    = rows[rd_idx];
    assign div_a_tgt = bank_a[rd_row.bank];
    assign div_b_tgt = bank_b[rd_row.bank];
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
    import fsel_pkg::*;
#(
    parameter int QUAL_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_s0,
    input  logic             strap_s1,
    input  logic             live_s2,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    localparam int CNT_W = $clog2(QUAL_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYC - 1);

    sel_state_t       state;
    sel_state_t       state_nxt;
    logic             s2_meta;
    logic             s2_sync;
    logic [CNT_W-1:0] qual_cnt;
    logic             differs;

    assign differs = (s2_sync != idx[IDX_W-1]);

    // two-flop synchronizer for the live select pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_meta <= 1'b0;
            s2_sync <= 1'b0;
        end else begin
            s2_meta <= live_s2;
            s2_sync <= s2_meta;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STRAP;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STRAP: state_nxt = ST_RUN;
            ST_RUN: begin
                if (differs) begin
                    state_nxt = ST_QUAL;
                end
            end
            ST_QUAL: begin
                if (!differs || (qual_cnt == CNT_LAST)) begin
                    state_nxt = ST_RUN;
                end
            end
            default: state_nxt = ST_STRAP;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            valid    <= 1'b0;
            qual_cnt <= '0;
        end else begin
            unique case (state)
                ST_STRAP: begin
                    idx      <= {s2_sync, {(IDX_W-2){1'b0}}, strap_s1, strap_s0};
                    valid    <= 1'b1;
                    qual_cnt <= '0;
                end
                ST_RUN: begin
                    qual_cnt <= '0;
                end
                ST_QUAL: begin
                    if (!differs) begin
                        qual_cnt <= '0;
                    end else if (qual_cnt == CNT_LAST) begin
                        idx[IDX_W-1] <= s2_sync;
                        qual_cnt     <= '0;
                    end else begin
                        qual_cnt <= qual_cnt + 1'b1;
                    end
                end
                default: qual_cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/fsel_postdiv.sv
module fsel_postdiv #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] target,
    output logic [W-1:0] act,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = (act == '0) ? '0 : act - 1'b1;
    assign tick = run && (cnt == last);

    // ratio reload only at terminal count keeps each period whole
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            act <= '0;
        end else if (run) begin
            if (tick) begin
                cnt <= '0;
                act <= target;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsel_table.sv
module fsel_table
    import fsel_pkg::*;
#(
    parameter int QUAL_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_sda,
    input  logic              strap_scl,
    input  logic              sel_live,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              cfg_valid,
    output logic [P_W-1:0]    pll_p,
    output logic [Q_W-1:0]    pll_q,
    output logic              bank_sel,
    output logic [D_W-1:0]    div_a_act,
    output logic [D_W-1:0]    div_b_act,
    output logic              tick_a,
    output logic              tick_b
);
    row_t           cur_row;
    logic [D_W-1:0] tgt_a;
    logic [D_W-1:0] tgt_b;

    fsel_ctrl #(.QUAL_CYC(QUAL_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_s0 (strap_sda),
        .strap_s1 (strap_scl),
        .live_s2  (sel_live),
        .idx      (sel_idx),
        .valid    (cfg_valid)
    );

    fsel_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_idx    (sel_idx),
        .rd_row    (cur_row),
        .div_a_tgt (tgt_a),
        .div_b_tgt (tgt_b)
    );

    fsel_postdiv #(.W(D_W)) u_div_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_valid),
        .target (tgt_a),
        .act    (div_a_act),
        .tick   (tick_a)
    );

    fsel_postdiv #(.W(D_W)) u_div_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cfg_valid),
        .target (tgt_b),
        .act    (div_b_act),
        .tick   (tick_b)
    );

    assign pll_p    = cur_row.p;
    assign pll_q    = cur_row.q;
    assign bank_sel = cur_row.bank;
endmodule

// File: rtl/fsel_table_chk.sv
module fsel_table_chk
    import fsel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  sel_idx,
    input logic              cfg_valid,
    input logic [P_W-1:0]    pll_p,
    input logic [Q_W-1:0]    pll_q,
    input logic              bank_sel,
    input logic [D_W-1:0]    div_a_act,
    input logic [D_W-1:0]    div_b_act,
    input logic              tick_a,
    input logic              tick_b
);
    AST_QUIET_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (!tick_a && !tick_b)); // R1

    AST_VALID_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_valid) |-> cfg_valid); // R2

    AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && $past(cfg_valid)) |-> (sel_idx[1:0] == $past(sel_idx[1:0]))); // R2

    AST_SWAP_AT_TERMINAL_A: assert property (@(posedge clk) disable iff (!rst_n)
        (div_a_act != $past(div_a_act)) |-> $past(tick_a)); // R7

    AST_SWAP_AT_TERMINAL_B: assert property (@(posedge clk) disable iff (!rst_n)
        (div_b_act != $past(div_b_act)) |-> $past(tick_b)); // R7

    AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_valid) && (sel_idx == $past(sel_idx)) && !$past(wr_en))
        |-> ($stable(pll_p) && $stable(pll_q) && $stable(bank_sel))); // R9
endmodule

bind fsel_table fsel_table_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .sel_idx   (sel_idx),
    .cfg_valid (cfg_valid),
    .pll_p     (pll_p),
    .pll_q     (pll_q),
    .bank_sel  (bank_sel),
    .div_a_act (div_a_act),
    .div_b_act (div_b_act),
    .tick_a    (tick_a),
    .tick_b    (tick_b)
);

// File: tb/tb_fsel_table.sv
module tb_fsel_table;
    import fsel_pkg::*;

    localparam int CLK_NS = 20;

    typedef struct {
        int p;
        int q;
        int bank;
        int da;
        int db;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strap_sda = 1'b1;
    logic              strap_scl = 1'b0;
    logic              sel_live = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [IDX_W-1:0]  sel_idx;
    logic              cfg_valid;
    logic [P_W-1:0]    pll_p;
    logic [Q_W-1:0]    pll_q;
    logic              bank_sel;
    logic [D_W-1:0]    div_a_act;
    logic [D_W-1:0]    div_b_act;
    logic              tick_a;
    logic              tick_b;

    int checks = 0;
    int errors = 0;
    exp_t sbq[$];

    int model_p [8];
    int model_q [8];
    int model_bk[8];
    int bank_a  [2];
    int bank_b  [2];

    bit watch_on = 0;
    int wa0, wa1, wb0, wb1;
    int gap_a = 0;
    int gap_b = 0;

    always #(CLK_NS / 2) clk = ~clk;

    fsel_table #(.QUAL_CYC(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_sda (strap_sda),
        .strap_scl (strap_scl),
        .sel_live  (sel_live),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sel_idx   (sel_idx),
        .cfg_valid (cfg_valid),
        .pll_p     (pll_p),
        .pll_q     (pll_q),
        .bank_sel  (bank_sel),
        .div_a_act (div_a_act),
        .div_b_act (div_b_act),
        .tick_a    (tick_a),
        .tick_b    (tick_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // driver: waits for the design to settle, then queues the expected row
    task automatic expect_row(input int row, input int settle, input string tag);
        exp_t e;
        repeat (settle) @(negedge clk);
        e.p    = model_p[row];
        e.q    = model_q[row];
        e.bank = model_bk[row];
        e.da   = bank_a[model_bk[row]];
        e.db   = bank_b[model_bk[row]];
        e.tag  = tag;
        sbq.push_back(e);
        #1;
    endtask

    task automatic measure(input bit sel_b, output int per);
        int n = 0;
        do @(negedge clk); while (!(sel_b ? tick_b : tick_a));
        do begin
            @(negedge clk);
            n++;
        end while (!(sel_b ? tick_b : tick_a));
        per = n;
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            exp_t e;
            wait (sbq.size() != 0);
            e = sbq.pop_front();
            chk(int'(pll_p) == e.p, {e.tag, " R4 pll_p"}, int'(pll_p), e.p);
            chk(int'(pll_q) == e.q, {e.tag, " R4 pll_q"}, int'(pll_q), e.q);
            chk(int'(bank_sel) == e.bank, {e.tag, " R4 bank_sel"}, int'(bank_sel), e.bank);
            chk(int'(div_a_act) == e.da, {e.tag, " R8 div_a_act"}, int'(div_a_act), e.da);
            chk(int'(div_b_act) == e.db, {e.tag, " R8 div_b_act"}, int'(div_b_act), e.db);
        end
    end

    // interval watcher for the glitch-free switch (R7)
    always @(negedge clk) begin
        if (rst_n && cfg_valid) begin
            if (tick_a) begin
                if (watch_on)
                    chk(gap_a == wa0 || gap_a == wa1, "R7 interval A", gap_a, wa1);
                gap_a = 1;
            end else begin
                gap_a = gap_a + 1;
            end
            if (tick_b) begin
                if (watch_on)
                    chk(gap_b == wb0 || gap_b == wb1, "R7 interval B", gap_b, wb1);
                gap_b = 1;
            end else begin
                gap_b = gap_b + 1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int per;
        for (int k = 0; k < 8; k++) begin
            model_p[k]  = 100 + 7 * k;
            model_q[k]  = 10 + k;
            model_bk[k] = (k & 1) ^ ((k >> 2) & 1);
        end
        bank_a[0] = 3; bank_a[1] = 4;
        bank_b[0] = 5; bank_b[1] = 6;

        repeat (4) @(negedge clk);
        chk(cfg_valid == 1'b0, "R1 cfg_valid in reset", int'(cfg_valid), 0);
        chk(sel_idx == '0, "R1 sel_idx in reset", int'(sel_idx), 0);
        chk(!tick_a && !tick_b, "R1 ticks in reset", int'(tick_a | tick_b), 0);

        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_valid == 1'b1, "R2 cfg_valid after strap", int'(cfg_valid), 1);
        chk(sel_idx == 3'd1, "R2 strap capture", int'(sel_idx), 1);

        for (int k = 0; k < 8; k++)
            wr(k, (model_bk[k] << 19) | (model_q[k] << 11) | model_p[k]);
        wr(8, (bank_b[0] << 7) | bank_a[0]);
        wr(9, (bank_b[1] << 7) | bank_a[1]);
        expect_row(1, 40, "row1");
        measure(1'b0, per);
        chk(per == 4, "R6 period A", per, 4);
        measure(1'b1, per);
        chk(per == 6, "R6 period B", per, 6);

        strap_sda = 1'b0;
        strap_scl = 1'b1;
        repeat (10) @(negedge clk);
        chk(sel_idx == 3'd1, "R2 straps ignored later", int'(sel_idx), 1);
        expect_row(1, 0, "straps moved");

        sel_live = 1'b1;
        @(negedge clk);
        sel_live = 1'b0;
        repeat (10) @(negedge clk);
        chk(sel_idx == 3'd1, "R3 one-cycle pulse ignored", int'(sel_idx), 1);
        sel_live = 1'b1;
        repeat (2) @(negedge clk);
        sel_live = 1'b0;
        repeat (10) @(negedge clk);
        chk(sel_idx == 3'd1, "R3 two-cycle pulse ignored", int'(sel_idx), 1);
        expect_row(1, 0, "after pulses R9");

        wa0 = 4; wa1 = 3; wb0 = 6; wb1 = 5;
        watch_on = 1;
        sel_live = 1'b1;
        repeat (60) @(negedge clk);
        watch_on = 0;
        chk(sel_idx == 3'd5, "R3 held level adopted", int'(sel_idx), 5);
        expect_row(5, 0, "row5");
        measure(1'b0, per);
        chk(per == 3, "R7 new period A", per, 3);

        wr(5, (model_bk[5] << 19) | (model_q[5] << 11) | 500);
        chk(pll_p == 11'd500, "R5 row write visible", int'(pll_p), 500);
        model_p[5] = 500;

        bank_a[0] = 9; bank_b[0] = 2;
        wa0 = 3; wa1 = 9; wb0 = 5; wb1 = 2;
        watch_on = 1;
        wr(8, (bank_b[0] << 7) | bank_a[0]);
        repeat (40) @(negedge clk);
        watch_on = 0;
        expect_row(5, 0, "bank write R5");
        measure(1'b0, per);
        chk(per == 9, "R6 period A after bank write", per, 9);

        bank_b[0] = 0;
        wr(8, (bank_b[0] << 7) | bank_a[0]);
        repeat (20) @(negedge clk);
        measure(1'b1, per);
        chk(per == 1, "R6 zero ratio acts as one", per, 1);

        sel_live = 1'b0;
        expect_row(1, 30, "back to row1");
        chk(sel_idx == 3'd1, "R3 return to low level", int'(sel_idx), 1);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule